// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is the host-facing side of a parallel printer interface. A CPU reaches it through a chip select, a 3-bit register address, separate active-low read and write strobes and an 8-bit data bus. The CPU-side signals are sampled on the block clock. Through the register set the CPU loads the byte presented on the printer data lines. It also reads back the printer's status lines and drives the two open-drain control lines that start an autofeed or an initialisation.

The printer acknowledge input is active low: a low pulse marks a completed transfer. The block synchronises it and latches a pending flag when the acknowledge returns high, on the trailing edge. It raises an active-high printer interrupt while that flag is set and the interrupt enable bit is on. Reading the status register clears the flag. A separate output-disable input removes the drive from the printer data lines, so that they can be read as inputs through the data register address.

Top module: `lpt_port`

## Requirements
- R1: After reset the data register and the control register are 0, the interrupt pending flag is clear, `prn_irq` is low, and `afd_pull` and `init_pull` are low. No control line is pulled.
- R2: A write strobe (`wr_n` low while `sel_n` is low) to address 0 loads `din` into the data register once per strobe. `pd_o` shows the new value from the clock edge that sees the strobe.
- R3: While `sel_n` is high, writes have no effect and `dout` reads 0x00.
- R4: `pd_oe` is high when `pd_hiz_req` is low and low when `pd_hiz_req` is high. `pd_o` keeps the data register value in both cases.
- R5: A read of address 0 returns the data register while the outputs are enabled. While `pd_hiz_req` is high it returns the synchronised `pd_i` pins.
- R6: A read of address 1 (status) returns `busy` in bit 7, the synchronised `ack_n` level in bit 6, the synchronised `err_n` level in bit 5 and the interrupt pending flag in bit 2. All other bits are 0.
- R7: A rising transition of the synchronised `ack_n` sets the pending flag. A falling transition does not.
- R8: `prn_irq` is high exactly while the pending flag is set and control bit 4 (interrupt enable) is 1. Clearing the enable bit holds `prn_irq` low but keeps the flag.
- R9: The clock edge that follows the end of a status read clears the pending flag. Reads of other addresses leave it alone. If an acknowledge edge coincides with that clearing edge, the flag stays set.
- R10: Address 2 is the control register. Bit 0 drives `afd_pull`, bit 1 drives `init_pull` and bit 4 is the interrupt enable. Reads return those three bits in place, other bits read 0 and writes to them are dropped.
- R11: Addresses 3 to 7 read 0x00, and writes to them change neither the data register nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low chip select for this port |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Write data from the CPU |
| dout | output | 8 | Read data to the CPU, 0 when no read is active |
| ack_n | input | 1 | Printer acknowledge, active low |
| busy | input | 1 | Printer busy, high when it cannot take data |
| err_n | input | 1 | Printer error, held low during an error |
| pd_hiz_req | input | 1 | High requests that the data lines float |
| pd_i | input | 8 | Printer data line levels as seen at the pins |
| pd_o | output | 8 | Data register value toward the pins |
| pd_oe | output | 1 | Drive enable for the data lines |
| afd_pull | output | 1 | High pulls the open-drain autofeed line low |
| init_pull | output | 1 | High pulls the open-drain initialise line low |
| prn_irq | output | 1 | Active-high printer interrupt |

## Verification
The hardest case to reach from the ports is an acknowledge edge that leaves the synchroniser on the same clock edge as the end of a status read, so that setting and clearing the pending flag compete. The bench starts a status read, then raises `ack_n` exactly two cycles before releasing `rd_n`. With the two-stage synchroniser, the rising edge then lands on the clearing edge, and the bench expects the flag and `prn_irq` to survive. Constrained random sequences of register accesses, acknowledge pulses, output-disable toggles and status changes then run against a bench model of the registers.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_STAT = 3'd1;
  localparam logic [AW-1:0] A_CTRL = 3'd2;

  localparam int ST_BUSY = 7;
  localparam int ST_ACK  = 6;
  localparam int ST_ERR  = 5;
  localparam int ST_PEND = 2;

  localparam int CT_AFD  = 0;
  localparam int CT_INIT = 1;
  localparam int CT_IEN  = 4;

  typedef struct packed {
    logic ien;
    logic init;
    logic afd;
  } ctrl_t;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_rest
      assign stage_d = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= RST_VAL;
      else        chain_q[s] <= stage_d;
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_host_if.sv
module lpt_host_if
  import lpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic          wr_stb,
  output logic          rd_act,
  output logic          rd_clr
);
  logic          acc_rd, acc_wr;
  logic          rd_prev_q, wr_prev_q;
  logic [AW-1:0] rd_addr_q, rd_addr_d;
  logic          rd_addr_en;

  assign acc_rd = !sel_n && !rd_n;
  assign acc_wr = !sel_n && !wr_n;

  // One write per strobe: commit on the first sampled cycle only
  assign wr_stb = acc_wr && !wr_prev_q;
  assign rd_act = acc_rd;

  always_comb begin
    rd_addr_en = acc_rd && !rd_prev_q;
    rd_addr_d  = addr;
  end

  // Read finished on this edge and it targeted status
  assign rd_clr = rd_prev_q && !acc_rd && (rd_addr_q == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b0;
      wr_prev_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_prev_q <= acc_rd;
      wr_prev_q <= acc_wr;
      if (rd_addr_en) rd_addr_q <= rd_addr_d;
    end
  end
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          rd_act,
  input  logic          rd_clr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          ack_rise,
  input  logic          busy_s,
  input  logic          ack_s,
  input  logic          err_s,
  input  logic [DW-1:0] pd_s,
  input  logic          pd_hiz_req,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] data_q,
  output ctrl_t         ctrl_q,
  output logic          pend_q,
  output logic          prn_irq
);
  logic [DW-1:0] data_d;
  logic          data_en;
  ctrl_t         ctrl_d;
  logic          ctrl_en;
  logic          pend_d;
  logic [DW-1:0] stat_w, ctrl_w, rd_mux;

  always_comb begin
    data_en = wr_stb && (addr == A_DATA);
    data_d  = din;
    ctrl_en = wr_stb && (addr == A_CTRL);
    ctrl_d.afd  = din[CT_AFD];
    ctrl_d.init = din[CT_INIT];
    ctrl_d.ien  = din[CT_IEN];
    // A new edge outranks the clear from a status read
    if (ack_rise)    pend_d = 1'b1;
    else if (rd_clr) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[ST_BUSY] = busy_s;
    stat_w[ST_ACK]  = ack_s;
    stat_w[ST_ERR]  = err_s;
    stat_w[ST_PEND] = pend_q;
    ctrl_w = '0;
    ctrl_w[CT_AFD]  = ctrl_q.afd;
    ctrl_w[CT_INIT] = ctrl_q.init;
    ctrl_w[CT_IEN]  = ctrl_q.ien;
    case (addr)
      A_DATA:  rd_mux = pd_hiz_req ? pd_s : data_q;
      A_STAT:  rd_mux = stat_w;
      A_CTRL:  rd_mux = ctrl_w;
      default: rd_mux = '0;
    endcase
    dout = rd_act ? rd_mux : '0;
  end

  assign prn_irq = pend_q && ctrl_q.ien;
endmodule

// File: rtl/lpt_port.sv
module lpt_port
  import lpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic          ack_n,
  input  logic          busy,
  input  logic          err_n,
  input  logic          pd_hiz_req,
  input  logic [DW-1:0] pd_i,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe,
  output logic          afd_pull,
  output logic          init_pull,
  output logic          prn_irq
);
  localparam int RST_STAGES = 2;
  localparam int STAT_W = 3;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  logic [STAT_W-1:0] stat_s;
  logic [DW-1:0]     pd_s;
  logic              ack_s, busy_s, err_s;

  // Order: {ack_n, busy, err_n}; idle levels ack high, busy low, error high
  lpt_sync #(.W(STAT_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_stat_sync (
    .clk(clk), .rst_n(rst_sync_n), .d({ack_n, busy, err_n}), .q(stat_s)
  );
  lpt_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pd_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pd_i), .q(pd_s)
  );
  assign ack_s  = stat_s[2];
  assign busy_s = stat_s[1];
  assign err_s  = stat_s[0];

  logic ack_prev_q, ack_rise;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ack_prev_q <= 1'b1;
    else             ack_prev_q <= ack_s;
  end
  assign ack_rise = ack_s && !ack_prev_q;

  logic wr_stb, rd_act, rd_clr;
  lpt_host_if u_host (
    .clk(clk), .rst_n(rst_sync_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wr_stb(wr_stb), .rd_act(rd_act), .rd_clr(rd_clr)
  );

  logic [DW-1:0] data_q;
  ctrl_t         ctrl_q;
  logic          pend_q;
  lpt_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .rd_act(rd_act),
    .rd_clr(rd_clr), .addr(addr), .din(din), .ack_rise(ack_rise),
    .busy_s(busy_s), .ack_s(ack_s), .err_s(err_s), .pd_s(pd_s),
    .pd_hiz_req(pd_hiz_req), .dout(dout), .data_q(data_q), .ctrl_q(ctrl_q),
    .pend_q(pend_q), .prn_irq(prn_irq)
  );

  assign pd_o      = data_q;
  assign pd_oe     = !pd_hiz_req;
  assign afd_pull  = ctrl_q.afd;
  assign init_pull = ctrl_q.init;
endmodule

// File: rtl/lpt_port_chk.sv
module lpt_port_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       sel_n,
  input logic [2:0] addr,
  input logic [7:0] din,
  input logic [7:0] dout,
  input logic [7:0] pd_o,
  input logic       prn_irq,
  input logic       wr_stb,
  input logic       rd_clr,
  input logic       ack_rise,
  input logic       pend_q,
  input logic       ien
);
  // R3: no read data escapes while deselected
  p_quiet_unsel_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_n |-> dout == 8'h00);

  // R2: a data write strobe shows up on the pins next cycle
  p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb && addr == 3'd0) |=> pd_o == $past(din));

  // R8: interrupt held low while disabled
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ien |-> !prn_irq);

  // R7: the flag only rises after a trailing acknowledge edge
  p_pend_src_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pend_q) |-> $past(ack_rise));

  // R9: end of status read clears the flag unless an edge coincides
  p_pend_clr_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_clr && !ack_rise) |=> !pend_q);

  // R9: coincident edge wins
  p_pend_keep_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_clr && ack_rise) |=> pend_q);
endmodule

bind lpt_port lpt_port_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .sel_n(sel_n), .addr(addr), .din(din),
  .dout(dout), .pd_o(pd_o), .prn_irq(prn_irq), .wr_stb(wr_stb),
  .rd_clr(rd_clr), .ack_rise(ack_rise), .pend_q(pend_q), .ien(ctrl_q.ien)
);

// File: tb/lpt_port_tb.sv
module lpt_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_n, rd_n, wr_n;
  logic [2:0] addr;
  logic [7:0] din, dout;
  logic       ack_n, busy, err_n, pd_hiz_req;
  logic [7:0] pd_i, pd_o;
  logic       pd_oe, afd_pull, init_pull, prn_irq;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0] m_data;
  logic       m_afd, m_init, m_ien, m_pend;

  always #2 clk = ~clk;

  lpt_port dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr), .rd_n(rd_n),
    .wr_n(wr_n), .din(din), .dout(dout), .ack_n(ack_n), .busy(busy),
    .err_n(err_n), .pd_hiz_req(pd_hiz_req), .pd_i(pd_i), .pd_o(pd_o),
    .pd_oe(pd_oe), .afd_pull(afd_pull), .init_pull(init_pull),
    .prn_irq(prn_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return pd_hiz_req ? pd_i : m_data;
      3'd1: return {busy, ack_n, err_n, 2'b00, m_pend, 2'b00};
      3'd2: return {3'b000, m_ien, 2'b00, m_init, m_afd};
      default: return 8'h00;
    endcase
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    sel_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
    idle(1);
    wr_n = 1'b1; sel_n = 1'b1;
    idle(1);
    if (a == 3'd0) m_data = d;
    if (a == 3'd2) begin m_afd = d[0]; m_init = d[1]; m_ien = d[4]; end
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] v);
    sel_n = 1'b0; addr = a; rd_n = 1'b0;
    #1 v = dout;
    idle(1);
    rd_n = 1'b1; sel_n = 1'b1;
    idle(1);
    if (a == 3'd1) m_pend = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a);
    logic [7:0] e, v;
    e = exp_read(a);
    host_rd(a, v);
    chk(tag, v, e);
  endtask

  task automatic ack_pulse();
    ack_n = 1'b0; idle(3);
    ack_n = 1'b1; idle(5);
    m_pend = 1'b1;
  endtask

  task automatic chk_pins(input string tag);
    chk({tag, " pd_o"}, pd_o, m_data);
    chk({tag, " pd_oe"}, {7'd0, pd_oe}, {7'd0, !pd_hiz_req});
    chk({tag, " ctl"}, {6'd0, init_pull, afd_pull}, {6'd0, m_init, m_afd});
    chk({tag, " irq"}, {7'd0, prn_irq}, {7'd0, m_pend & m_ien});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    rst_n = 1'b0; sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
    ack_n = 1'b1; busy = 1'b0; err_n = 1'b1; pd_hiz_req = 1'b0; pd_i = 8'h00;
    m_data = '0; m_afd = 0; m_init = 0; m_ien = 0; m_pend = 0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk_pins("R1 reset");
    rd_chk("R1 ctrl reset", 3'd2);
    rd_chk("R1 data reset", 3'd0);

    // R2 write data, R5 readback with drive on
    host_wr(3'd0, 8'hA5);
    chk("R2 pd_o", pd_o, 8'hA5);
    rd_chk("R5 data enabled", 3'd0);

    // R3 deselected access
    sel_n = 1'b1; addr = 3'd0; din = 8'h3C; wr_n = 1'b0; idle(1); wr_n = 1'b1; idle(1);
    chk("R3 write ignored", pd_o, 8'hA5);
    rd_n = 1'b0; addr = 3'd2; #1 chk("R3 read quiet", dout, 8'h00);
    idle(1); rd_n = 1'b1; idle(1);

    // R4/R5 output disable
    pd_hiz_req = 1'b1; pd_i = 8'h5A; idle(3);
    chk("R4 oe off", {7'd0, pd_oe}, 8'h00);
    chk("R4 pd_o held", pd_o, 8'hA5);
    rd_chk("R5 data pins", 3'd0);
    pd_hiz_req = 1'b0; idle(1);
    chk("R4 oe on", {7'd0, pd_oe}, 8'h01);

    // R6 status
    busy = 1'b1; err_n = 1'b0; idle(4);
    rd_chk("R6 status", 3'd1);
    busy = 1'b0; err_n = 1'b1; idle(4);
    rd_chk("R6 status idle", 3'd1);

    // R10 control
    host_wr(3'd2, 8'h13);
    chk_pins("R10 ctrl set");
    host_wr(3'd2, 8'hFF);
    rd_chk("R10 ctrl masked", 3'd2);

    // R7 falling edge alone sets nothing
    ack_n = 1'b0; idle(5);
    chk("R7 fall no irq", {7'd0, prn_irq}, 8'h00);
    rd_chk("R6 ack low level", 3'd1);
    ack_n = 1'b1; idle(5);
    m_pend = 1'b1;
    chk("R7 rise sets irq", {7'd0, prn_irq}, 8'h01);

    // R9 only status reads clear
    rd_chk("R9 data read", 3'd0);
    chk("R9 kept after data read", {7'd0, prn_irq}, 8'h01);
    rd_chk("R9 status shows pend", 3'd1);
    chk("R9 cleared", {7'd0, prn_irq}, 8'h00);

    // R8 enable gating keeps flag
    ack_pulse();
    host_wr(3'd2, 8'h00);
    chk("R8 gated low", {7'd0, prn_irq}, 8'h00);
    host_wr(3'd2, 8'h10);
    chk("R8 flag kept", {7'd0, prn_irq}, 8'h01);
    rd_chk("R9 clear again", 3'd1);

    // R11 unmapped
    for (int a = 3; a < 8; a++) begin
      host_wr(a[2:0], 8'hC3);
      rd_chk("R11 unmapped read", a[2:0]);
    end
    chk_pins("R11 no side effect");

    // R9 coincident edge and clear: edge wins
    ack_n = 1'b0; idle(5);
    sel_n = 1'b0; addr = 3'd1; rd_n = 1'b0;
    idle(1);
    ack_n = 1'b1;
    idle(2);
    rd_n = 1'b1; sel_n = 1'b1;
    idle(2);
    chk("R9 edge beats clear", {7'd0, prn_irq}, 8'h01);
    m_pend = 1'b1;
    rd_chk("R9 status after race", 3'd1);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: host_wr(3'($urandom_range(0, 7)), 8'($urandom));
        1: rd_chk("R5 R6 R10 R11 random read", 3'($urandom_range(0, 7)));
        2: begin pd_hiz_req = ~pd_hiz_req; idle(1); end
        3: begin pd_i = 8'($urandom); idle(3); end
        4: begin busy = 1'($urandom); err_n = 1'($urandom); idle(4); end
        5: ack_pulse();
        default: rd_chk("R9 random status", 3'd1);
      endcase
      chk_pins("R2 R4 R8 R10 random pins");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule